// File: doc/BRIEF.md
# Switch Reset Strap Sequencer

This block brings an external switch device out of reset when that device cannot be trusted to reset itself at power-up. After one start request it runs a fixed three-phase pattern on the device's reset/control line. The line is driven high, then driven low, then driven high again, and it stays driven high once the pattern ends. While the line is low and during the final high phase, the block also drives the shared serial clock line high and the serial data line low. The device samples these strap levels when its reset rises. The serial chip-select line is never driven.

When the last phase expires, the block releases the clock, data and chip-select lines to high impedance and raises a one-cycle completion pulse. A serial configuration master can then take over those lines. Each phase length is a parameter counted in milliseconds. A prescaler parameter, in clocks per millisecond, turns each millisecond count into clock cycles.

The control machine has six states. `SQ_IDLE` is the state after reset, with every output enable low. `SQ_DRIVE_HI` is the first high phase. `SQ_PULL_LO` is the low phase, with the straps driven. `SQ_RELEASE_HI` is the final high phase, with the straps still driven. `SQ_DONE` lasts one cycle and carries the completion pulse. `SQ_HOLD` keeps reset driven high with the serial lines released.

The transitions are as follows. `start_i` moves `SQ_IDLE` or `SQ_HOLD` to `SQ_DRIVE_HI`. Phase expiry moves `SQ_DRIVE_HI` to `SQ_PULL_LO`, `SQ_PULL_LO` to `SQ_RELEASE_HI`, and `SQ_RELEASE_HI` to `SQ_DONE`. `SQ_DONE` always moves to `SQ_HOLD`. Every other state ignores `start_i`.

Top module: `strap_seq`

## Requirements
- R1: Immediately after reset, and until the first accepted start, every output enable (`sw_rst_oe_o`, `sclk_oe_o`, `sdat_oe_o`, `csel_oe_o`), every output value and `done_o` are 0.
- R2: A start seen at a clock edge in idle or hold makes the first phase begin after that edge. In that phase, reset is driven high (`sw_rst_oe_o`=1, `sw_rst_o`=1) and the clock and data enables stay 0. The phase lasts exactly HIGH_MS*CLK_PER_MS cycles.
- R3: The second phase drives reset low (`sw_rst_oe_o`=1, `sw_rst_o`=0) for exactly LOW_MS*CLK_PER_MS cycles.
- R4: In the second and third phases the strap levels are driven: `sclk_oe_o`=1 with `sclk_o`=1, and `sdat_oe_o`=1 with `sdat_o`=0.
- R5: The third phase drives reset high for exactly REL_MS*CLK_PER_MS cycles.
- R6: In the cycle right after the third phase, `done_o` is 1 for exactly one cycle. In that cycle reset is still driven high and the clock and data enables are 0.
- R7: After the completion pulse, reset stays driven high and the clock, data and chip-select enables stay 0 until the next accepted start.
- R8: The chip-select line is never driven: `csel_oe_o` and `csel_o` are always 0.
- R9: A start seen in any state other than idle or hold has no effect on the outputs. A start seen in hold restarts the full sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, sampled at each clock edge |
| sw_rst_o | output | 1 | Reset/control line value |
| sw_rst_oe_o | output | 1 | Reset/control line output enable |
| sclk_o | output | 1 | Serial clock line value (strap) |
| sclk_oe_o | output | 1 | Serial clock line output enable |
| sdat_o | output | 1 | Serial data line value (strap) |
| sdat_oe_o | output | 1 | Serial data line output enable |
| csel_o | output | 1 | Serial chip-select line value |
| csel_oe_o | output | 1 | Serial chip-select output enable |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `rst_n` is held low for at least one edge before the first use. The low-phase length check also assumes that each phase parameter is at least 1 and CLK_PER_MS is at least 2, so that each phase lasts more than one cycle. The stimulus uses small phase and prescaler values within those limits. It applies `start_i` only as single-cycle pulses, timed so that no pulse lands in the one-cycle completion state; this keeps the expected waveform a function only of the cycles elapsed since the accepted start.

// File: rtl/strap_seq_pkg.sv
package strap_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_DRIVE_HI,
        SQ_PULL_LO,
        SQ_RELEASE_HI,
        SQ_DONE,
        SQ_HOLD
    } seq_state_e;

endpackage

// File: rtl/strap_ms_tick.sv
module strap_ms_tick #(
    parameter int CLK_PER_MS = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);
    localparam int CW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_MS - 1);

    logic [CW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (restart_i || div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick_o = (div_q == LAST);
endmodule

// File: rtl/strap_phase_timer.sv
module strap_phase_timer #(
    parameter int MS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [MS_W-1:0] load_ms_i,
    input  logic            tick_i,
    output logic            expire_o
);
    logic [MS_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load_i) begin
            left_q <= load_ms_i;
        end else if (tick_i && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign expire_o = tick_i && (left_q == MS_W'(1));
endmodule

// File: rtl/strap_seq.sv
module strap_seq
    import strap_seq_pkg::*;
#(
    parameter int CLK_PER_MS = 100000,
    parameter int HIGH_MS    = 20,
    parameter int LOW_MS     = 100,
    parameter int REL_MS     = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic sw_rst_o,
    output logic sw_rst_oe_o,
    output logic sclk_o,
    output logic sclk_oe_o,
    output logic sdat_o,
    output logic sdat_oe_o,
    output logic csel_o,
    output logic csel_oe_o,
    output logic done_o
);
    localparam int MAX_A  = (HIGH_MS > LOW_MS) ? HIGH_MS : LOW_MS;
    localparam int MAX_MS = (MAX_A > REL_MS) ? MAX_A : REL_MS;
    localparam int MS_W   = $clog2(MAX_MS + 1);

    seq_state_e      state_q, state_d;
    logic            load;
    logic [MS_W-1:0] load_ms;
    logic            tick;
    logic            expire;

    strap_ms_tick #(.CLK_PER_MS(CLK_PER_MS)) tick_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (load),
        .tick_o    (tick)
    );

    strap_phase_timer #(.MS_W(MS_W)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .load_ms_i (load_ms),
        .tick_i    (tick),
        .expire_o  (expire)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and phase loading
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        load_ms = '0;
        unique case (state_q)
            SQ_IDLE, SQ_HOLD: begin
                if (start_i) begin
                    state_d = SQ_DRIVE_HI;
                    load    = 1'b1;
                    load_ms = MS_W'(HIGH_MS);
                end
            end
            SQ_DRIVE_HI: begin
                if (expire) begin
                    state_d = SQ_PULL_LO;
                    load    = 1'b1;
                    load_ms = MS_W'(LOW_MS);
                end
            end
            SQ_PULL_LO: begin
                if (expire) begin
                    state_d = SQ_RELEASE_HI;
                    load    = 1'b1;
                    load_ms = MS_W'(REL_MS);
                end
            end
            SQ_RELEASE_HI: begin
                if (expire) begin
                    state_d = SQ_DONE;
                end
            end
            SQ_DONE: begin
                state_d = SQ_HOLD;
            end
            default: begin
                state_d = SQ_IDLE;
            end
        endcase
    end

    // Outputs per state
    always_comb begin
        sw_rst_o    = 1'b0;
        sw_rst_oe_o = 1'b0;
        sclk_o      = 1'b0;
        sclk_oe_o   = 1'b0;
        sdat_o      = 1'b0;
        sdat_oe_o   = 1'b0;
        csel_o      = 1'b0;
        csel_oe_o   = 1'b0;
        done_o      = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
            end
            SQ_DRIVE_HI: begin
                sw_rst_oe_o = 1'b1;
                sw_rst_o    = 1'b1;
            end
            SQ_PULL_LO: begin
                sw_rst_oe_o = 1'b1;
                sclk_oe_o   = 1'b1;
                sclk_o      = 1'b1;
                sdat_oe_o   = 1'b1;
            end
            SQ_RELEASE_HI: begin
                sw_rst_oe_o = 1'b1;
                sw_rst_o    = 1'b1;
                sclk_oe_o   = 1'b1;
                sclk_o      = 1'b1;
                sdat_oe_o   = 1'b1;
            end
            SQ_DONE: begin
                sw_rst_oe_o = 1'b1;
                sw_rst_o    = 1'b1;
                done_o      = 1'b1;
            end
            SQ_HOLD: begin
                sw_rst_oe_o = 1'b1;
                sw_rst_o    = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/strap_seq_chk.sv
module strap_seq_chk #(
    parameter int CLK_PER_MS = 100000,
    parameter int LOW_MS     = 100
) (
    input logic clk,
    input logic rst_n,
    input logic sw_rst_o,
    input logic sw_rst_oe_o,
    input logic sclk_o,
    input logic sclk_oe_o,
    input logic sdat_o,
    input logic sdat_oe_o,
    input logic csel_oe_o,
    input logic done_o
);
    localparam int LOW_CYC = CLK_PER_MS * LOW_MS;

    int low_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run <= 0;
        end else if (sw_rst_oe_o && !sw_rst_o) begin
            low_run <= low_run + 1;
        end else begin
            low_run <= 0;
        end
    end

    AST_LOW_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rst_oe_o && $past(sw_rst_oe_o) && $rose(sw_rst_o)) |-> (low_run == LOW_CYC)); // R3
    AST_STRAP_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_oe_o |-> (sclk_o && sdat_oe_o && !sdat_o)); // R4
    AST_STRAP_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rst_oe_o && !sw_rst_o) |-> (sclk_oe_o && sdat_oe_o)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (sw_rst_oe_o && sw_rst_o && !sclk_oe_o && !sdat_oe_o)); // R6
    AST_RST_KEPT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst_oe_o |=> sw_rst_oe_o); // R7
    AST_NO_CSEL: assert property (@(posedge clk) disable iff (!rst_n)
        !csel_oe_o); // R8
endmodule

bind strap_seq strap_seq_chk #(
    .CLK_PER_MS (CLK_PER_MS),
    .LOW_MS     (LOW_MS)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_rst_o    (sw_rst_o),
    .sw_rst_oe_o (sw_rst_oe_o),
    .sclk_o      (sclk_o),
    .sclk_oe_o   (sclk_oe_o),
    .sdat_o      (sdat_o),
    .sdat_oe_o   (sdat_oe_o),
    .csel_oe_o   (csel_oe_o),
    .done_o      (done_o)
);

// File: tb/strap_seq_tb_top.sv
`timescale 1ns/1ps
module strap_seq_tb_top;
    localparam int K   = 3;
    localparam int HI  = 2;
    localparam int LO  = 4;
    localparam int REL = 3;
    localparam int A   = HI * K;
    localparam int B   = LO * K;
    localparam int C   = REL * K;
    localparam int END = A + B + C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic sw_rst, sw_rst_oe, sclk, sclk_oe, sdat, sdat_oe, csel, csel_oe, done;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    strap_seq #(.CLK_PER_MS(K), .HIGH_MS(HI), .LOW_MS(LO), .REL_MS(REL)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .sw_rst_o(sw_rst), .sw_rst_oe_o(sw_rst_oe),
        .sclk_o(sclk), .sclk_oe_o(sclk_oe),
        .sdat_o(sdat), .sdat_oe_o(sdat_oe),
        .csel_o(csel), .csel_oe_o(csel_oe),
        .done_o(done)
    );

    // Output bit order: rst_oe rst sclk_oe sclk sdat_oe sdat csel_oe csel done
    function automatic logic [8:0] obs();
        return {sw_rst_oe, sw_rst, sclk_oe, sclk, sdat_oe, sdat, csel_oe, csel, done};
    endfunction

    function automatic logic [8:0] model(int t);
        if (t < A)        return 9'b11_00_00_00_0;  // R2
        if (t < A + B)    return 9'b10_11_10_00_0;  // R3 R4
        if (t < END)      return 9'b11_11_10_00_0;  // R5 R4
        if (t == END)     return 9'b11_00_00_00_1;  // R6
        return 9'b11_00_00_00_0;                    // R7
    endfunction

    function automatic string req_of(int t);
        if (t < A)     return "R2";
        if (t < A + B) return "R3/R4";
        if (t < END)   return "R5/R4";
        if (t == END)  return "R6";
        return "R7";
    endfunction

    task automatic check(string req, logic [8:0] act, logic [8:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Pulse start for one edge; on return the accepted edge has passed, now at negedge t=0.
    task automatic issue_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Follow one full sequence; optionally pulse start in non-idle states (R9).
    task automatic follow_sequence(string tag, bit pulse_mid, int extra);
        for (int t = 0; t <= END + extra; t++) begin
            check(req_of(t), obs(), model(t));
            if (pulse_mid && (t == 1 || t == A || t == A + B + 1 || t == END - 2))
                start = 1'b1;
            else
                start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        if (pulse_mid) check({"R9 ", tag}, obs(), model(END + extra + 1));
    endtask

    task automatic test_reset_state();
        for (int i = 0; i < 5; i++) begin
            check("R1", obs(), 9'b0);
            check("R8", {csel_oe, csel}, 2'b00);
            @(negedge clk);
        end
    endtask

    task automatic test_first_sequence();
        issue_start();
        follow_sequence("first", 1'b0, 8);
    endtask

    task automatic test_hold_stays();
        for (int i = 0; i < 30; i++) begin
            check("R7", obs(), 9'b11_00_00_00_0);
            @(negedge clk);
        end
    endtask

    task automatic test_restart_with_noise();
        issue_start();   // R9: start from hold restarts
        follow_sequence("ignored", 1'b1, 4);
    endtask

    task automatic test_back_to_back_restart();
        issue_start();
        follow_sequence("again", 1'b0, 2);
        check("R8", {csel_oe, csel}, 2'b00);
    endtask

    initial begin
        #(200_000 * 10);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset_state();
        test_first_sequence();
        test_hold_stays();
        test_restart_with_noise();
        test_back_to_back_restart();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule